// File: doc/BRIEF.md
# Latched-Address Nonvolatile Memory Bus Bridge

This block couples a small parallel nonvolatile memory to an 8-bit processor bus through three decoded locations. The memory has no address input of its own that the processor can drive directly: instead, any write into a 64-byte write window captures the low six address bits into an address latch that feeds the memory address pins, and on the same strobe captures the data byte into a write latch that feeds the memory data inputs. A separate control location holds four bits that drive the memory's control lines. A read location returns the memory's data pins to the bus.

Because the address is only captured on writes, reading a memory location takes two steps: a throwaway write to the wanted location (which loads the address latch), then a read of the read location. During such a read the bus returns either the memory data or, if the control register enables it, the write latch contents.

The upstream decoder supplies a single select for the block's 256-byte region; the block splits that region into four quarters using the top two offset bits: quarter 0 is the write window, quarter 1 the control register, quarter 2 the read location, and quarter 3 is unused.

Top module: `eebr_bridge`

## Requirements
- R1: After a synchronous active-low reset, the control outputs are all 0 (memory idle, write-latch bus drive off), the address latch is 0 and the write latch is 0.
- R2: A bus write with select high and offset bits [7:6] = 0 loads offset bits [5:0] into `mem_addr` at that clock edge.
- R3: The same write loads the full data byte into the write latch, seen on `mem_wdata` at that edge.
- R4: A bus write with offset bits [7:6] = 1 loads data bits [3:0] into `mem_ctrl` (bit 0 write-latch bus drive, bit 1 memory enable, bit 2 memory write, bit 3 memory output enable); data bits [7:4] are ignored.
- R5: Writes with select low, or to quarters 2 and 3, change neither latch nor the control register.
- R6: A bus read with select high and offset bits [7:6] = 2 returns `mem_rdata` on `bus_rdata` in the same cycle while control bit 0 is 0.
- R7: The same read returns the write latch contents while control bit 0 is 1.
- R8: `bus_rdata` is 0 whenever no read of quarter 2 is in progress.
- R9: Reads never change the address latch, so a read returns data for the address of the last write-window write.
- R10: A control register write leaves the address and write latches unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Region select from the address decoder |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Offset within the region |
| bus_wdata | input | 8 | Write data from the processor |
| bus_rdata | output | 8 | Read data to the processor |
| mem_addr | output | 6 | Latched memory address |
| mem_wdata | output | 8 | Write latch contents to memory data inputs |
| mem_rdata | input | 8 | Memory data outputs |
| mem_ctrl | output | 4 | Latched control lines |

## Verification
Latch and control results are due one clock after the write strobe: the bench drives a write for one cycle starting at a falling edge and checks the latched outputs at the next falling edge, just after the capturing rising edge. Read data is combinational, so read checks sample a short delay after the falling edge on which the read strobe is applied, in the same cycle. The memory model in the bench writes on a rising edge while memory enable and write are both set, so memory contents used by later reads are settled before those reads begin.

// File: rtl/eebr_pkg.sv
// Shared definitions for the nonvolatile memory bus bridge.
// Assumes the region offset's top two bits pick one of four quarters.
package eebr_pkg;
    typedef enum logic [1:0] {
        Q_WLATCH = 2'd0,
        Q_CTRL   = 2'd1,
        Q_READ   = 2'd2,
        Q_SPARE  = 2'd3
    } quarter_e;

    // Control register bit positions
    localparam int CTL_WLOE = 0;
    localparam int CTL_CE   = 1;
    localparam int CTL_WE   = 2;
    localparam int CTL_OE   = 3;
endpackage

// File: rtl/eebr_decode.sv
// Quarter decoder: turns select, strobes and offset into one-hot actions.
// Assumes strobes are qualified by bus_sel and valid for a whole cycle.
module eebr_decode
    import eebr_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [OFS_W-1:0] bus_addr,
    output logic             ld_latch,
    output logic             ld_ctrl,
    output logic             rd_hit
);
    localparam int QHI = OFS_W - 1;
    localparam int QLO = OFS_W - 2;

    quarter_e q;

    // Decode the quarter and qualify it with select and strobe
    always_comb begin
        q        = quarter_e'(bus_addr[QHI:QLO]);
        ld_latch = bus_sel && bus_wr && (q == Q_WLATCH);
        ld_ctrl  = bus_sel && bus_wr && (q == Q_CTRL);
        rd_hit   = bus_sel && bus_rd && (q == Q_READ);
    end
endmodule

// File: rtl/eebr_wlatch.sv
// Address and write-data latches, loaded together by one write strobe.
// Assumes MEM_AW does not exceed the bits below the quarter field.
module eebr_wlatch #(
    parameter int OFS_W  = 8,
    parameter int MEM_AW = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] din,
    output logic [MEM_AW-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    // Capture address and data on a write-window strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (ld) begin
            addr_q <= ofs[MEM_AW-1:0];
            data_q <= din;
        end
    end

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> addr_q == $past(ofs[MEM_AW-1:0])); // R2
    AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> data_q == $past(din)); // R3
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(addr_q) && $stable(data_q)); // R5
endmodule

// File: rtl/eebr_ctrl.sv
// Control register: keeps the low CTRL_W bits of a control write.
// Assumes CTRL_W is not wider than the data bus.
module eebr_ctrl #(
    parameter int DATA_W = 8,
    parameter int CTRL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [DATA_W-1:0] din,
    output logic [CTRL_W-1:0] ctrl_q
);
    // Load control bits; reset leaves the memory idle
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else if (ld) ctrl_q <= din[CTRL_W-1:0];
    end

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> ctrl_q == $past(din[CTRL_W-1:0])); // R4
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(ctrl_q)); // R5
endmodule

// File: rtl/eebr_rdmux.sv
// Read path: gates either memory data or the write latch onto the bus.
// Assumes the bus expects zero when the read location is not addressed.
module eebr_rdmux #(
    parameter int DATA_W = 8
) (
    input  logic              rd_hit,
    input  logic              wl_oe,
    input  logic [DATA_W-1:0] latch_d,
    input  logic [DATA_W-1:0] mem_d,
    output logic [DATA_W-1:0] bus_d
);
    // Pick the source per bit, then gate with the read hit
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign bus_d[i] = rd_hit & (wl_oe ? latch_d[i] : mem_d[i]);
    end
endmodule

// File: rtl/eebr_bridge.sv
// Top of the nonvolatile memory bus bridge.
// Assumes bus_sel comes from an external decoder for a 2**OFS_W byte region.
module eebr_bridge
    import eebr_pkg::*;
#(
    parameter int OFS_W  = 8,
    parameter int MEM_AW = 6,
    parameter int DATA_W = 8,
    parameter int CTRL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CTRL_W-1:0] mem_ctrl
);
    logic ld_latch;
    logic ld_ctrl;
    logic rd_hit;

    eebr_decode #(.OFS_W(OFS_W)) u_dec (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_rd  (bus_rd),
        .bus_addr(bus_addr),
        .ld_latch(ld_latch),
        .ld_ctrl (ld_ctrl),
        .rd_hit  (rd_hit)
    );

    eebr_wlatch #(.OFS_W(OFS_W), .MEM_AW(MEM_AW), .DATA_W(DATA_W)) u_wl (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld_latch),
        .ofs   (bus_addr),
        .din   (bus_wdata),
        .addr_q(mem_addr),
        .data_q(mem_wdata)
    );

    eebr_ctrl #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld_ctrl),
        .din   (bus_wdata),
        .ctrl_q(mem_ctrl)
    );

    eebr_rdmux #(.DATA_W(DATA_W)) u_rd (
        .rd_hit (rd_hit),
        .wl_oe  (mem_ctrl[CTL_WLOE]),
        .latch_d(mem_wdata),
        .mem_d  (mem_rdata),
        .bus_d  (bus_rdata)
    );

    AST_RD_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr) |=> $stable(mem_addr)); // R9
    AST_CTRL_WR_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr[OFS_W-1:OFS_W-2] == 2'd1)
        |=> $stable(mem_addr) && $stable(mem_wdata)); // R10
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0); // R8
endmodule

// File: tb/sim_eebr_bridge.sv
module sim_eebr_bridge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [5:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;
    logic [3:0] mem_ctrl;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    eebr_bridge u0 (.*);

    // Memory model: write when enable and write set; drive when enable and output enable set
    logic [7:0] arr [64];
    initial for (int i = 0; i < 64; i++) arr[i] = 8'(i) ^ 8'h5A;
    always @(posedge clk) if (mem_ctrl[1] && mem_ctrl[2]) arr[mem_addr] <= mem_wdata;
    assign mem_rdata = (mem_ctrl[1] && mem_ctrl[3]) ? arr[mem_addr] : 8'h00;

    localparam logic [3:0] OP_WR = 4'd1, OP_RD = 4'd2, OP_CA = 4'd3, OP_CC = 4'd4, OP_CW = 4'd5;
    // {op, req, addr, data, expected}
    localparam int NV = 21;
    localparam logic [31:0] VEC [NV] = '{
        {OP_WR, 4'd2,  8'h05, 8'hA5, 8'h00},  // R2 write window
        {OP_CA, 4'd2,  8'h00, 8'h00, 8'h05},  // R2
        {OP_CW, 4'd3,  8'h00, 8'h00, 8'hA5},  // R3
        {OP_WR, 4'd4,  8'h40, 8'hF6, 8'h00},  // R4 upper nibble ignored
        {OP_CC, 4'd4,  8'h00, 8'h00, 8'h06},  // R4
        {OP_CA, 4'd10, 8'h00, 8'h00, 8'h05},  // R10
        {OP_WR, 4'd4,  8'h40, 8'h0A, 8'h00},  // R4
        {OP_CC, 4'd4,  8'h00, 8'h00, 8'h0A},  // R4
        {OP_RD, 4'd6,  8'h80, 8'h00, 8'hA5},  // R6 memory written earlier
        {OP_WR, 4'd2,  8'h12, 8'h3C, 8'h00},  // R2 dummy write before read
        {OP_RD, 4'd6,  8'h80, 8'h00, 8'h48},  // R6 0x12^0x5A
        {OP_WR, 4'd4,  8'h41, 8'h0B, 8'h00},  // R4
        {OP_CC, 4'd4,  8'h00, 8'h00, 8'h0B},  // R4
        {OP_RD, 4'd7,  8'h80, 8'h00, 8'h3C},  // R7 write latch on bus
        {OP_RD, 4'd8,  8'h00, 8'h00, 8'h00},  // R8 wrong quarter
        {OP_WR, 4'd5,  8'h85, 8'h77, 8'h00},  // R5 quarter 2 write
        {OP_CA, 4'd5,  8'h00, 8'h00, 8'h12},  // R5
        {OP_CW, 4'd5,  8'h00, 8'h00, 8'h3C},  // R5
        {OP_CA, 4'd9,  8'h00, 8'h00, 8'h12},  // R9 reads left address alone
        {OP_WR, 4'd5,  8'hC3, 8'h05, 8'h00},  // R5 quarter 3 write
        {OP_CC, 4'd5,  8'h00, 8'h00, 8'h0B}   // R5
    };

    task automatic check(input string what, input int rq, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic sel, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
        #1;
    endtask

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("reset ctrl", 1, {4'h0, mem_ctrl}, 8'h00);
        check("reset addr", 1, {2'b00, mem_addr}, 8'h00);
        check("reset wlatch", 1, mem_wdata, 8'h00);
        // R8 idle bus returns zero
        check("idle rdata", 8, bus_rdata, 8'h00);

        for (int k = 0; k < NV; k++) begin
            logic [3:0] op; logic [3:0] rq; logic [7:0] a, d, e;
            {op, rq, a, d, e} = VEC[k];
            case (op)
                OP_WR: bus_write(1'b1, a, d);
                OP_RD: begin bus_read(a, rd); check("read", int'(rq), rd, e); end
                OP_CA: check("addr latch", int'(rq), {2'b00, mem_addr}, e);
                OP_CC: check("ctrl", int'(rq), {4'h0, mem_ctrl}, e);
                OP_CW: check("write latch", int'(rq), mem_wdata, e);
                default: ;
            endcase
        end

        // R5 write with select low is ignored
        bus_write(1'b0, 8'h33, 8'h99);
        check("sel low addr", 5, {2'b00, mem_addr}, 8'h12);
        check("sel low wlatch", 5, mem_wdata, 8'h3C);
        // R10 control write keeps latches, then read path returns memory again (R6)
        bus_write(1'b1, 8'h7F, 8'hFA);
        check("ctrl top offset", 4, {4'h0, mem_ctrl}, 8'h0A);
        check("ctrl keeps wlatch", 10, mem_wdata, 8'h3C);
        bus_read(8'hBF, rd);
        check("read top of quarter 2", 6, rd, 8'h48);
        // R1 reset mid-run clears control and latches
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check("re-reset ctrl", 1, {4'h0, mem_ctrl}, 8'h00);
        check("re-reset addr", 1, {2'b00, mem_addr}, 8'h00);
        check("re-reset wlatch", 1, mem_wdata, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule